// File: doc/BRIEF.md
# Bridge I/O Forwarding Decoder

This block sits on the downstream port of a PCI-to-PCI bridge. It decides whether a processor-initiated I/O or memory request is passed down the link. Each request arrives as a one-cycle strobe with an address and a flag that marks it as I/O or memory. The decision comes back registered, one clock later, together with its own valid strobe.

Three configuration inputs and a programmed I/O window set the decision. The window is a base block and a limit block, each 4 KB aligned. An ISA switch removes from that window the top three quarters of every 1 KB block. A VGA switch claims the legacy display I/O ports and the legacy display memory, whatever the window and the ISA switch say. A further switch selects how many address bits the VGA port compare uses: 10 bits, so that aliases every 1 KB also hit, or all 16 bits.

Top module: `bridge_fwd_decode`

## Requirements
- R1: While the synchronous reset `rst` is high, the next clock edge drives `rspValid` and `rspForward` to 0, even with a request present.
- R2: `rspValid` is high exactly in the cycle after a cycle with `reqValid` high, and low otherwise. `rspForward` is 0 whenever `rspValid` is 0.
- R3: Take an I/O request (`reqIsIo`=1) with ISA and VGA both off. It is forwarded exactly when block number `reqAddr[15:12]` lies in `ioBaseBlk`..`ioLimitBlk`, both ends included. Bits `reqAddr[31:16]` play no part in an I/O decision.
- R4: When `ioBaseBlk` is greater than `ioLimitBlk`, the window is empty and claims no I/O address.
- R5: With `isaExclEn`=1, an I/O address whose bits [9:8] are not 00 is not forwarded through the window. The switch never forwards an address that the window does not claim.
- R6: With `vgaRouteEn`=1 and `vgaFullDecode`=0, an I/O request is forwarded when `reqAddr[9:0]` is in 3B0h..3BBh or 3C0h..3DFh, whatever the value of bits [15:10].
- R7: With `vgaRouteEn`=1 and `vgaFullDecode`=1, the VGA port match also requires `reqAddr[15:10]` to be 0.
- R8: With `vgaRouteEn`=0, `vgaFullDecode` has no effect on any decision.
- R9: A memory request (`reqIsIo`=0) is forwarded only when `vgaRouteEn`=1 and the full address is in A0000h..BFFFFh.
- R10: A VGA port match forwards the request even when the address is outside the window or is removed by the ISA switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request strobe, one cycle per request |
| reqAddr | input | ADDR_W (32) | Request address |
| reqIsIo | input | 1 | 1 = I/O request, 0 = memory request |
| ioBaseBlk | input | IO_W-WIN_LSB (4) | First 4 KB block of the I/O window |
| ioLimitBlk | input | IO_W-WIN_LSB (4) | Last 4 KB block of the I/O window |
| isaExclEn | input | 1 | Remove the ISA alias quarters from the window |
| vgaRouteEn | input | 1 | Claim the legacy VGA port and memory ranges |
| vgaFullDecode | input | 1 | VGA port compare on 16 bits instead of 10 |
| rspValid | output | 1 | Decision strobe, one clock after the request |
| rspForward | output | 1 | 1 = forward downstream |

## Verification
The sweep runs every 10-bit block offset under several upper address patterns, for each mix of the three switches and for a valid and an empty window. This covers the exact ends 3BBh, 3C0h and 3DFh, the ISA cut at offset 100h, and the first and last window blocks. Each of these faults shows up in the sweep: an off-by-one range compare drops or gains one port, an ISA cut that adds addresses forwards an out-of-window alias, and a full-decode switch that acts without VGA changes an unrelated decision. A VGA match that does not override the window loses aliases outside 0..3FFh. Memory probes at 9FFFFh, C0000h and at addresses that alias the port ranges catch a decoder that confuses the two spaces. Idle gaps show a valid strobe that lingers for a cycle.

// File: rtl/fwd_decode_pkg.sv
package fwd_decode_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic load;
  } fwdStrobe_t;
endpackage

// File: rtl/fwd_decode_ctrl.sv
module fwd_decode_ctrl
  import fwd_decode_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  output fwdStrobe_t strobe,
  output logic       rspValid
);
  always_comb begin
    strobe.clear = rst;
    strobe.load  = reqValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) rspValid <= 1'b0;
    else     rspValid <= reqValid;
  end
endmodule

// File: rtl/fwd_decode_dp.sv
module fwd_decode_dp
  import fwd_decode_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IO_W     = 16,
  parameter int WIN_LSB  = 12,
  parameter int BLK_BITS = 10
) (
  input  logic                     clk,
  input  fwdStrobe_t               strobe,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic                     reqIsIo,
  input  logic [IO_W-WIN_LSB-1:0]  ioBaseBlk,
  input  logic [IO_W-WIN_LSB-1:0]  ioLimitBlk,
  input  logic                     isaExclEn,
  input  logic                     vgaRouteEn,
  input  logic                     vgaFullDecode,
  output logic                     rspForward
);
  localparam int WIN_W    = IO_W - WIN_LSB;
  localparam int ALIAS_W  = IO_W - BLK_BITS;
  localparam int N_VGA_IO = 2;
  localparam logic [ADDR_W-1:0] VGA_MEM_LO = ADDR_W'(32'h000A_0000);
  localparam logic [ADDR_W-1:0] VGA_MEM_HI = ADDR_W'(32'h000B_FFFF);
  localparam logic [N_VGA_IO-1:0][BLK_BITS-1:0] VGA_IO_LO = {BLK_BITS'(10'h3C0), BLK_BITS'(10'h3B0)};
  localparam logic [N_VGA_IO-1:0][BLK_BITS-1:0] VGA_IO_HI = {BLK_BITS'(10'h3DF), BLK_BITS'(10'h3BB)};

  logic [IO_W-1:0]     ioAddr;
  logic [WIN_W-1:0]    addrBlk;
  logic [BLK_BITS-1:0] blkOffset;
  logic [ALIAS_W-1:0]  aliasBits;
  logic [N_VGA_IO-1:0] portHit;
  logic windowHit, isaCut, vgaIoHit, vgaMemHit, decision;

  assign ioAddr    = reqAddr[IO_W-1:0];
  assign addrBlk   = ioAddr[IO_W-1:WIN_LSB];
  assign blkOffset = ioAddr[BLK_BITS-1:0];
  assign aliasBits = ioAddr[IO_W-1:BLK_BITS];

  // legacy display port ranges, one comparator pair per range
  for (genvar g = 0; g < N_VGA_IO; g++) begin : g_vgaPort
    assign portHit[g] = (blkOffset >= VGA_IO_LO[g]) && (blkOffset <= VGA_IO_HI[g]);
  end

  always_comb begin
    windowHit = (ioBaseBlk <= ioLimitBlk) && (addrBlk >= ioBaseBlk) && (addrBlk <= ioLimitBlk);
    isaCut    = isaExclEn && (blkOffset[BLK_BITS-1:BLK_BITS-2] != 2'b00);
    vgaIoHit  = vgaRouteEn && (|portHit) && (!vgaFullDecode || (aliasBits == '0));
    vgaMemHit = vgaRouteEn && (reqAddr >= VGA_MEM_LO) && (reqAddr <= VGA_MEM_HI);
    if (reqIsIo) decision = vgaIoHit || (windowHit && !isaCut);
    else         decision = vgaMemHit;
  end

  always_ff @(posedge clk) begin
    if (strobe.clear)     rspForward <= 1'b0;
    else if (strobe.load) rspForward <= decision;
    else                  rspForward <= 1'b0;
  end
endmodule

// File: rtl/bridge_fwd_decode.sv
module bridge_fwd_decode
  import fwd_decode_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IO_W     = 16,
  parameter int WIN_LSB  = 12,
  parameter int BLK_BITS = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reqValid,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic                    reqIsIo,
  input  logic [IO_W-WIN_LSB-1:0] ioBaseBlk,
  input  logic [IO_W-WIN_LSB-1:0] ioLimitBlk,
  input  logic                    isaExclEn,
  input  logic                    vgaRouteEn,
  input  logic                    vgaFullDecode,
  output logic                    rspValid,
  output logic                    rspForward
);
  fwdStrobe_t strobe;

  fwd_decode_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .strobe   (strobe),
    .rspValid (rspValid)
  );

  fwd_decode_dp #(
    .ADDR_W   (ADDR_W),
    .IO_W     (IO_W),
    .WIN_LSB  (WIN_LSB),
    .BLK_BITS (BLK_BITS)
  ) i_dp (
    .clk           (clk),
    .strobe        (strobe),
    .reqAddr       (reqAddr),
    .reqIsIo       (reqIsIo),
    .ioBaseBlk     (ioBaseBlk),
    .ioLimitBlk    (ioLimitBlk),
    .isaExclEn     (isaExclEn),
    .vgaRouteEn    (vgaRouteEn),
    .vgaFullDecode (vgaFullDecode),
    .rspForward    (rspForward)
  );
endmodule

// File: rtl/fwd_decode_chk.sv
module fwd_decode_chk #(
  parameter int ADDR_W   = 32,
  parameter int IO_W     = 16,
  parameter int WIN_LSB  = 12,
  parameter int BLK_BITS = 10
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    reqValid,
  input logic [ADDR_W-1:0]       reqAddr,
  input logic                    reqIsIo,
  input logic [IO_W-WIN_LSB-1:0] ioBaseBlk,
  input logic [IO_W-WIN_LSB-1:0] ioLimitBlk,
  input logic                    isaExclEn,
  input logic                    vgaRouteEn,
  input logic                    vgaFullDecode,
  input logic                    rspValid,
  input logic                    rspForward
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!rspValid && !rspForward));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> rspValid);

  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !rspValid);

  assert_fwd_needs_valid_R2: assert property (@(posedge clk) disable iff (rst)
    !rspValid |-> !rspForward);

  assert_empty_window_R4: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqIsIo && !vgaRouteEn && (ioBaseBlk > ioLimitBlk)) |=> !rspForward);

  assert_isa_cut_R5: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqIsIo && !vgaRouteEn && isaExclEn &&
     (reqAddr[BLK_BITS-1:BLK_BITS-2] != 2'b00)) |=> !rspForward);

  assert_vga_alias_R6: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqIsIo && vgaRouteEn && !vgaFullDecode &&
     (reqAddr[BLK_BITS-1:0] == BLK_BITS'(10'h3C0))) |=> rspForward);

  assert_mem_gated_R9: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !reqIsIo && !vgaRouteEn) |=> !rspForward);
endmodule

bind bridge_fwd_decode fwd_decode_chk #(
  .ADDR_W   (ADDR_W),
  .IO_W     (IO_W),
  .WIN_LSB  (WIN_LSB),
  .BLK_BITS (BLK_BITS)
) i_chk (
  .clk           (clk),
  .rst           (rst),
  .reqValid      (reqValid),
  .reqAddr       (reqAddr),
  .reqIsIo       (reqIsIo),
  .ioBaseBlk     (ioBaseBlk),
  .ioLimitBlk    (ioLimitBlk),
  .isaExclEn     (isaExclEn),
  .vgaRouteEn    (vgaRouteEn),
  .vgaFullDecode (vgaFullDecode),
  .rspValid      (rspValid),
  .rspForward    (rspForward)
);

// File: tb/test_bridge_fwd_decode.sv
module test_bridge_fwd_decode;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqIsIo = 1'b0;
  logic [3:0]  ioBaseBlk = '0;
  logic [3:0]  ioLimitBlk = '0;
  logic        isaExclEn = 1'b0;
  logic        vgaRouteEn = 1'b0;
  logic        vgaFullDecode = 1'b0;
  logic        rspValid, rspForward;

  int checks = 0;
  int failures = 0;

  // settings applied together with the next request
  logic       nIsa = 1'b0, nVga = 1'b0, nFull = 1'b0;
  logic [3:0] nBase = 4'd0, nLim = 4'd0;

  logic  pendV = 1'b0, pendF = 1'b0;
  string pendTag = "R2";

  always #5ns clk = ~clk;

  bridge_fwd_decode i_bridge_fwd_decode (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqAddr(reqAddr), .reqIsIo(reqIsIo),
    .ioBaseBlk(ioBaseBlk), .ioLimitBlk(ioLimitBlk), .isaExclEn(isaExclEn),
    .vgaRouteEn(vgaRouteEn), .vgaFullDecode(vgaFullDecode),
    .rspValid(rspValid), .rspForward(rspForward)
  );

  function automatic logic vgaPort(input int a16, input logic vga, input logic full);
    int low = a16 % 1024;
    logic inRange = ((low >= 944) && (low <= 955)) || ((low >= 960) && (low <= 991));
    return vga && inRange && (!full || (a16 < 1024));
  endfunction

  function automatic logic model(input logic [31:0] a, input logic io);
    int a16 = int'(a[15:0]);
    int blk = a16 / 4096;
    logic win = (nBase <= nLim) && (blk >= int'(nBase)) && (blk <= int'(nLim));
    logic cut = nIsa && ((a16 % 1024) >= 256);
    if (!io) return nVga && (a >= 32'h000A_0000) && (a <= 32'h000B_FFFF);
    return vgaPort(a16, nVga, nFull) || (win && !cut);
  endfunction

  function automatic string tagOf(input logic [31:0] a, input logic io);
    int a16 = int'(a[15:0]);
    int blk = a16 / 4096;
    logic win = (nBase <= nLim) && (blk >= int'(nBase)) && (blk <= int'(nLim));
    logic cut = nIsa && ((a16 % 1024) >= 256);
    if (!io) return "R9";
    if (vgaPort(a16, nVga, nFull)) return (!win || cut) ? "R10" : (nFull ? "R7" : "R6");
    if (nVga && vgaPort(a16, 1'b1, 1'b0)) return "R7";
    if (!nVga && nFull) return "R8";
    if (nIsa) return "R5";
    if (nBase > nLim) return "R4";
    return "R3";
  endfunction

  task automatic checkPending();
    checks++;
    if (rspValid !== pendV) begin
      failures++;
      $display("FAIL R2 rspValid actual=%0b expected=%0b", rspValid, pendV);
    end
    checks++;
    if (rspForward !== pendF) begin
      failures++;
      $display("FAIL %s rspForward addr=%h io=%0b isa=%0b vga=%0b full=%0b win=%0d..%0d actual=%0b expected=%0b",
               pendTag, reqAddr, reqIsIo, isaExclEn, vgaRouteEn, vgaFullDecode,
               ioBaseBlk, ioLimitBlk, rspForward, pendF);
    end
  endtask

  // one request (or idle) per cycle; checks the previous one first
  task automatic step(input logic v, input logic [31:0] a, input logic io);
    @(negedge clk);
    checkPending();
    reqValid = v; reqAddr = a; reqIsIo = io;
    isaExclEn = nIsa; vgaRouteEn = nVga; vgaFullDecode = nFull;
    ioBaseBlk = nBase; ioLimitBlk = nLim;
    pendV = v;
    pendF = v ? model(a, io) : 1'b0;
    pendTag = v ? tagOf(a, io) : "R2";
  endtask

  initial begin
    #1900us;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int hiSet[5] = '{0, 4, 12, 16, 63};
    logic [31:0] memSet[8] = '{32'h0009_FFFF, 32'h000A_0000, 32'h000A_83C0, 32'h000B_FFFF,
                               32'h000C_0000, 32'h001A_0000, 32'h0000_13C0, 32'h0000_03B0};
    // R1: reset with a request present
    nVga = 1'b1;
    @(negedge clk);
    rst = 1'b1; reqValid = 1'b1; reqIsIo = 1'b1; reqAddr = 32'h3C0;
    vgaRouteEn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (rspValid !== 1'b0 || rspForward !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset outputs actual=%0b%0b expected=00", rspValid, rspForward);
    end
    rst = 1'b0; reqValid = 1'b0;
    pendV = 1'b0; pendF = 1'b0;

    for (int cfg = 0; cfg < 16; cfg++) begin
      nIsa  = cfg[0];
      nVga  = cfg[1];
      nFull = cfg[2];
      nBase = cfg[3] ? 4'd4 : 4'd1;
      nLim  = cfg[3] ? 4'd2 : 4'd3;
      for (int h = 0; h < 5; h++) begin
        for (int low = 0; low < 1024; low++) begin
          logic [5:0] hi6 = 6'(hiSet[h]);
          step(1'b1, {16'hA5A5, hi6, 10'(low)}, 1'b1);
        end
        step(1'b0, 32'h0, 1'b1);  // R2 idle gap
      end
      for (int m = 0; m < 8; m++) step(1'b1, memSet[m], 1'b0);
      step(1'b0, 32'h0, 1'b0);
    end
    step(1'b0, 32'h0, 1'b0);
    @(negedge clk);
    checkPending();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule